// File: doc/BRIEF.md
# Timed scanline pixel streamer

This block produces a raster display signal one line at a time. A line counter sweeps from zero to a programmable last value and wraps. A compare on that counter gives horizontal sync, and every compare match also steps a line count that gives vertical sync. Both sync polarities are programmable.

At each line start a one-cycle arming stage prepares the pixel path. A free-running pace counter then releases one transfer cell each time it wraps. Each released cell takes one pixel word from a line-buffer read port and drives it onto a parallel pixel bus. After the line's last cell has gone out, the next pace wrap writes the black value, so black always follows the visible pixels. A dual-source mode spreads a line across two read ports, cell by cell. The black write then waits until both ports have delivered their share. If a line start arrives while a transfer is still running, that transfer is abandoned, black is forced at once and a sticky underrun flag is raised.

Top module: `scan_streamer`

## Requirements
- R1: The line counter starts at 0 after reset, increments every clock and returns to 0 after reaching `cfg_line_last`, so a line lasts `cfg_line_last`+1 cycles.
- R2: Horizontal sync is active in every cycle whose line count is at least `cfg_hsync_at`. `hsync_o` equals the active state when `cfg_hsync_high`=1 and its inverse when it is 0.
- R3: The frame line count steps once per line, on the cycle whose line count equals `cfg_hsync_at`, and wraps to 0 after `cfg_frame_lines`-1. Vertical sync is active while that count lies in [`cfg_vsync_first`, `cfg_vsync_last`], with polarity set by `cfg_vsync_high` in the same way as R2.
- R4: A line start (line count 0) puts the streamer in an arming cycle. Transfer opens in the cycle after that, so only pace wraps at least two cycles after the line start release cells.
- R5: The pace counter runs freely from 0 to `cfg_pace_last` and wraps. Each wrap during an open transfer updates `pix_o` in the following cycle. `pix_o` holds its value in all other cycles, except on a line-start abort.
- R6: With `cfg_dual`=0, cell n of a line is the word returned for `src0_addr`=n.
- R7: With `cfg_dual`=1, even cells come from port 0 and odd cells from port 1, both at address n/2, starting with port 0. Port 0 supplies ceil(cells/2) words and port 1 supplies floor(cells/2).
- R8: The pace wrap after the last of the `cfg_cells` cells writes the black value (all zeros by default). With `cfg_cells`=0, the first wrap of the open transfer writes black.
- R9: If a line starts while the previous line's transfer has not yet written black, `pix_o` is black from the next cycle and `underrun_o` rises and stays at 1 until reset.
- R10: A synchronous active-high `rst` clears all counters, drives black on `pix_o`, holds both syncs inactive and clears `underrun_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_line_last | input | CNT_W | Last value of the line counter |
| cfg_hsync_at | input | CNT_W | Line count where horizontal sync begins |
| cfg_hsync_high | input | 1 | 1: horizontal sync active high |
| cfg_frame_lines | input | LINE_W | Lines per frame |
| cfg_vsync_first | input | LINE_W | First line with vertical sync active |
| cfg_vsync_last | input | LINE_W | Last line with vertical sync active |
| cfg_vsync_high | input | 1 | 1: vertical sync active high |
| cfg_pace_last | input | PACE_W | Last value of the pace counter |
| cfg_cells | input | CELL_W | Cells per line |
| cfg_dual | input | 1 | 1: two alternating pixel sources |
| src0_addr | output | CELL_W | Read address, port 0 |
| src0_data | input | PIX_W | Read data, port 0, valid in the same cycle |
| src1_addr | output | CELL_W | Read address, port 1 |
| src1_data | input | PIX_W | Read data, port 1, valid in the same cycle |
| pix_o | output | PIX_W | Parallel pixel output |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| underrun_o | output | 1 | Sticky transfer-overrun flag |

## Verification
The bench checks every port on every cycle, so a fault in the line or pace counter shows up at once. A bad line counter shifts the sync edge within one line. A bad pace phase moves the first changed pixel by at least a cycle. If a port address is wrong or the port choice is swapped, the very first affected cell shows the wrong word. A missed frame step appears at the next vertical sync boundary. Bad completion tracking shows as a missing or early black write within one pace period. It also shows as a spurious underrun at the next line start.

// File: rtl/sls_pkg.sv
package sls_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ARM  = 2'd1,
      ST_RUN  = 2'd2
   } stream_state_t;

   localparam int unsigned SRC_PORTS = 2;
endpackage

// File: rtl/sls_line_timer.sv
module sls_line_timer #(
   parameter int unsigned CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] last_cnt,
   input  logic [CNT_W-1:0] sync_at,
   output logic             sync_active_o,
   output logic             line_step_o,
   output logic             line_start_o
);
   logic [CNT_W-1:0] pos_q;
   logic [CNT_W-1:0] pos_nxt;
   logic             sync_q;

   always_comb begin
      if (pos_q >= last_cnt) pos_nxt = '0;
      else                   pos_nxt = pos_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pos_q  <= '0;
         sync_q <= 1'b0;
      end else begin
         pos_q  <= pos_nxt;
         sync_q <= (pos_nxt >= sync_at);
      end
   end

   assign sync_active_o = sync_q;
   assign line_step_o   = (pos_q == sync_at);
   assign line_start_o  = (pos_q == '0);

   a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
      (pos_q >= last_cnt) |=> (pos_q == '0));
endmodule

// File: rtl/sls_frame_timer.sv
module sls_frame_timer #(
   parameter int unsigned LINE_W = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step,
   input  logic [LINE_W-1:0] frame_len,
   input  logic [LINE_W-1:0] band_first,
   input  logic [LINE_W-1:0] band_last,
   output logic              band_active_o
);
   logic [LINE_W-1:0] row_q;
   logic [LINE_W-1:0] row_nxt;
   logic [LINE_W:0]   row_inc;
   logic              band_q;

   assign row_inc = {1'b0, row_q} + 1'b1;

   always_comb begin
      row_nxt = row_q;
      if (step) begin
         if (row_inc >= {1'b0, frame_len}) row_nxt = '0;
         else                              row_nxt = row_inc[LINE_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         row_q  <= '0;
         band_q <= 1'b0;
      end else begin
         row_q  <= row_nxt;
         band_q <= (row_nxt >= band_first) && (row_nxt <= band_last);
      end
   end

   assign band_active_o = band_q;

   a_r3_step_only_on_event: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(row_q));
endmodule

// File: rtl/sls_pace_timer.sv
module sls_pace_timer #(
   parameter int unsigned PACE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [PACE_W-1:0] last_cnt,
   output logic              tick_o
);
   logic [PACE_W-1:0] beat_q;

   always_ff @(posedge clk) begin
      if (rst)                    beat_q <= '0;
      else if (beat_q >= last_cnt) beat_q <= '0;
      else                        beat_q <= beat_q + 1'b1;
   end

   assign tick_o = (beat_q >= last_cnt);

   a_r5_tick_restarts: assert property (@(posedge clk) disable iff (rst)
      tick_o |=> (beat_q == '0));
endmodule

// File: rtl/sls_channel.sv
module sls_channel #(
   parameter int unsigned CELL_W = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr,
   input  logic              fire,
   input  logic [CELL_W-1:0] quota,
   output logic [CELL_W-1:0] addr_o,
   output logic              done_o
);
   logic [CELL_W-1:0] taken_q;

   always_ff @(posedge clk) begin
      if (rst || clr) taken_q <= '0;
      else if (fire)  taken_q <= taken_q + 1'b1;
   end

   assign addr_o = taken_q;
   assign done_o = (taken_q >= quota);

   a_r7_within_quota: assert property (@(posedge clk) disable iff (rst)
      fire |-> !done_o);
endmodule

// File: rtl/scan_streamer.sv
module scan_streamer
   import sls_pkg::*;
#(
   parameter int unsigned CNT_W  = 12,
   parameter int unsigned LINE_W = 10,
   parameter int unsigned PACE_W = 8,
   parameter int unsigned CELL_W = 10,
   parameter int unsigned PIX_W  = 8,
   parameter logic [PIX_W-1:0] BLACK_PIX = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CNT_W-1:0]  cfg_line_last,
   input  logic [CNT_W-1:0]  cfg_hsync_at,
   input  logic              cfg_hsync_high,
   input  logic [LINE_W-1:0] cfg_frame_lines,
   input  logic [LINE_W-1:0] cfg_vsync_first,
   input  logic [LINE_W-1:0] cfg_vsync_last,
   input  logic              cfg_vsync_high,
   input  logic [PACE_W-1:0] cfg_pace_last,
   input  logic [CELL_W-1:0] cfg_cells,
   input  logic              cfg_dual,
   output logic [CELL_W-1:0] src0_addr,
   input  logic [PIX_W-1:0]  src0_data,
   output logic [CELL_W-1:0] src1_addr,
   input  logic [PIX_W-1:0]  src1_data,
   output logic [PIX_W-1:0]  pix_o,
   output logic              hsync_o,
   output logic              vsync_o,
   output logic              underrun_o
);
   localparam int unsigned NSRC = SRC_PORTS;

   if (CNT_W < 2)  begin : g_bad_cnt  $error("CNT_W must be at least 2");  end
   if (LINE_W < 1) begin : g_bad_line $error("LINE_W must be at least 1"); end
   if (PACE_W < 1) begin : g_bad_pace $error("PACE_W must be at least 1"); end
   if (CELL_W < 1) begin : g_bad_cell $error("CELL_W must be at least 1"); end
   if (PIX_W < 1)  begin : g_bad_pix  $error("PIX_W must be at least 1");  end

   logic hs_active, line_step, line_start, vs_active, tick;

   sls_line_timer #(.CNT_W(CNT_W)) u_line (
      .clk          (clk),
      .rst          (rst),
      .last_cnt     (cfg_line_last),
      .sync_at      (cfg_hsync_at),
      .sync_active_o(hs_active),
      .line_step_o  (line_step),
      .line_start_o (line_start)
   );

   sls_frame_timer #(.LINE_W(LINE_W)) u_frame (
      .clk          (clk),
      .rst          (rst),
      .step         (line_step),
      .frame_len    (cfg_frame_lines),
      .band_first   (cfg_vsync_first),
      .band_last    (cfg_vsync_last),
      .band_active_o(vs_active)
   );

   sls_pace_timer #(.PACE_W(PACE_W)) u_pace (
      .clk     (clk),
      .rst     (rst),
      .last_cnt(cfg_pace_last),
      .tick_o  (tick)
   );

   assign hsync_o = cfg_hsync_high ? hs_active : ~hs_active;
   assign vsync_o = cfg_vsync_high ? vs_active : ~vs_active;

   stream_state_t     state_q;
   logic              turn_q;
   logic              sel;
   logic              take, abort, all_done;
   logic [NSRC-1:0]   fire, done;
   logic [CELL_W-1:0] quota [NSRC];
   logic [CELL_W-1:0] addr  [NSRC];
   logic [PIX_W-1:0]  rdata [NSRC];
   logic [PIX_W-1:0]  pix_q;
   logic              underrun_q;

   assign quota[0] = cfg_dual ? (cfg_cells - (cfg_cells >> 1)) : cfg_cells;
   assign quota[1] = cfg_dual ? (cfg_cells >> 1) : '0;
   assign rdata[0] = src0_data;
   assign rdata[1] = src1_data;
   assign src0_addr = addr[0];
   assign src1_addr = addr[1];

   assign all_done = &done;
   assign abort    = line_start && (state_q != ST_IDLE);
   assign take     = (state_q == ST_RUN) && tick && !line_start;

   always_comb begin
      if (!cfg_dual)    sel = 1'b0;
      else if (done[0]) sel = 1'b1;
      else if (done[1]) sel = 1'b0;
      else              sel = turn_q;
   end

   for (genvar j = 0; j < NSRC; j++) begin : g_src
      assign fire[j] = take && !all_done && (sel == 1'(j));
      sls_channel #(.CELL_W(CELL_W)) u_chan (
         .clk   (clk),
         .rst   (rst),
         .clr   (state_q == ST_ARM),
         .fire  (fire[j]),
         .quota (quota[j]),
         .addr_o(addr[j]),
         .done_o(done[j])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         turn_q  <= 1'b0;
      end else begin
         if (line_start) begin
            state_q <= ST_ARM;
         end else begin
            case (state_q)
               ST_ARM:  state_q <= ST_RUN;
               ST_RUN:  if (take && all_done) state_q <= ST_IDLE;
               default: state_q <= state_q;
            endcase
         end
         if (state_q == ST_ARM)                turn_q <= 1'b0;
         else if (take && !all_done && cfg_dual) turn_q <= ~turn_q;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pix_q      <= BLACK_PIX;
         underrun_q <= 1'b0;
      end else begin
         if (abort) begin
            pix_q      <= BLACK_PIX;
            underrun_q <= 1'b1;
         end else if (take) begin
            pix_q <= all_done ? BLACK_PIX : rdata[sel];
         end
      end
   end

   assign pix_o      = pix_q;
   assign underrun_o = underrun_q;

   a_r5_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
      (!take && !abort) |=> $stable(pix_q));
   a_r9_underrun_sticky: assert property (@(posedge clk) disable iff (rst)
      underrun_q |=> underrun_q);
   a_r7_one_source: assert property (@(posedge clk) disable iff (rst)
      $onehot0(fire));
   a_r8_idle_is_black: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_IDLE) |-> (pix_q == BLACK_PIX));
endmodule

// File: tb/scan_streamer_test.sv
module scan_streamer_test;
   localparam int CW = 6, LW = 4, PW = 3, EW = 4, XW = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [CW-1:0] cfg_line_last, cfg_hsync_at;
   logic          cfg_hsync_high, cfg_vsync_high, cfg_dual;
   logic [LW-1:0] cfg_frame_lines, cfg_vsync_first, cfg_vsync_last;
   logic [PW-1:0] cfg_pace_last;
   logic [EW-1:0] cfg_cells;
   logic [EW-1:0] src0_addr, src1_addr;
   logic [XW-1:0] src0_data, src1_data, pix_o;
   logic          hsync_o, vsync_o, underrun_o;

   int n_checks = 0;
   int n_fail   = 0;

   always #10 clk = ~clk;

   assign src0_data = 8'h10 + {4'd0, src0_addr} * 8'd3;
   assign src1_data = 8'h80 + {4'd0, src1_addr} * 8'd5;

   scan_streamer #(.CNT_W(CW), .LINE_W(LW), .PACE_W(PW), .CELL_W(EW), .PIX_W(XW)) uut (
      .clk(clk), .rst(rst),
      .cfg_line_last(cfg_line_last), .cfg_hsync_at(cfg_hsync_at), .cfg_hsync_high(cfg_hsync_high),
      .cfg_frame_lines(cfg_frame_lines), .cfg_vsync_first(cfg_vsync_first),
      .cfg_vsync_last(cfg_vsync_last), .cfg_vsync_high(cfg_vsync_high),
      .cfg_pace_last(cfg_pace_last), .cfg_cells(cfg_cells), .cfg_dual(cfg_dual),
      .src0_addr(src0_addr), .src0_data(src0_data), .src1_addr(src1_addr), .src1_data(src1_data),
      .pix_o(pix_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .underrun_o(underrun_o)
   );

   task automatic check(input string req, input int act, input int exp, input int cyc);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
      end
   endtask

   // number of pace wraps in cycles [a,b]; wraps fall where cycle % q == q-1
   function automatic int wraps(input int a, input int b, input int q);
      if (b < a) return 0;
      return (b + 1) / q - a / q;
   endfunction

   function automatic int cell_word(input int n, input bit dual);
      int idx = dual ? n / 2 : n;
      if (dual && (n % 2 == 1)) return (8'h80 + idx * 5) & 8'hff;
      return (8'h10 + idx * 3) & 8'hff;
   endfunction

   task automatic run_cfg(input int ll, input int hs, input bit hpol, input int fl,
                          input int vf, input int vl, input bit vpol,
                          input int pl, input int cells, input bit dual, input int ncyc);
      int len = ll + 1;
      int q   = pl + 1;
      cfg_line_last   = CW'(ll);  cfg_hsync_at   = CW'(hs); cfg_hsync_high = hpol;
      cfg_frame_lines = LW'(fl);  cfg_vsync_first = LW'(vf); cfg_vsync_last = LW'(vl);
      cfg_vsync_high  = vpol;     cfg_pace_last  = PW'(pl); cfg_cells = EW'(cells);
      cfg_dual = dual;
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      for (int k = 0; k < ncyc; k++) begin
         int  b, n, e, row, exp_pix, exp_uf;
         bit  hact, vact;
         string tag;
         #1;
         // R1, R2: line position k % len, sync from the compare point to the end of line
         hact = (k % len) >= hs;
         check(k == 0 ? "R10" : "R1,R2", hsync_o, hpol ? hact : !hact, k);
         // R3: one frame step per compare match in earlier cycles
         e    = (k - 1 >= hs) ? (k - 1 - hs) / len + 1 : 0;
         row  = e % fl;
         vact = (row >= vf) && (row <= vl);
         check(k == 0 ? "R10" : "R3", vsync_o, vpol ? vact : !vact, k);
         // pixel path
         if (k == 0) begin
            exp_pix = 0; tag = "R10";
         end else begin
            b = ((k - 1) / len) * len;
            n = wraps(b + 2, k - 1, q);
            if (n == 0) begin
               exp_pix = 0; tag = (k == b + 1 && b > 0) ? "R9" : "R4";
            end else if (n <= cells) begin
               exp_pix = cell_word(n - 1, dual); tag = dual ? "R5,R7" : "R5,R6";
            end else begin
               exp_pix = 0; tag = "R8";
            end
         end
         check(tag, pix_o, exp_pix, k);
         exp_uf = 0;
         for (int s = len; s + 1 <= k; s += len)
            if (wraps(s - len + 2, s - 1, q) < cells + 1) exp_uf = 1;
         check(k == 0 ? "R10" : "R9", underrun_o, exp_uf, k);
         @(negedge clk);
      end
   endtask

   initial begin
      // single source, 6 cells paced every 4 cycles, active-high syncs
      run_cfg(39, 30, 1'b1, 5, 1, 2, 1'b1, 3, 6, 1'b0, 600);
      // dual source, odd cell count, pace every 3 cycles, line not a multiple of pace
      run_cfg(40, 33, 1'b1, 4, 2, 3, 1'b0, 2, 5, 1'b1, 600);
      // dual source at full rate, inverted syncs
      run_cfg(39, 25, 1'b0, 6, 1, 1, 1'b0, 0, 7, 1'b1, 500);
      // more cells than a line can carry: abort and sticky underrun
      run_cfg(39, 30, 1'b1, 5, 1, 2, 1'b1, 3, 12, 1'b0, 400);
      // zero cells: black at the first wrap of the open transfer
      run_cfg(29, 20, 1'b1, 3, 1, 2, 1'b1, 5, 0, 1'b0, 300);
      // dual with 15 cells at full rate, short frame
      run_cfg(35, 28, 1'b1, 3, 1, 1, 1'b1, 0, 15, 1'b1, 400);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 20);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule